// File: doc/BRIEF.md
# Double-Length Fixed-Point Divider

This block divides a positive double-length dividend by a positive single-word divisor for a 16-bit accumulator machine. The dividend spans two registers. The accumulator register (A) supplies the sign and the 15 high-order magnitude bits. The index register (X) supplies the 15 low-order bits, left-justified in bits 15..1, and its bit 0 carries no data. When the divisor is larger than the upper half, the block writes the 15-bit quotient back to X with a zero sign bit and the remainder to A. Otherwise it reports a divide fault by setting the overflow flag, and both registers keep their values.

The block takes one request at a time. A start pulse is accepted only while the block is idle. At that point it latches both registers, the divisor and the incoming overflow flag. A restoring shift-subtract loop then produces one quotient bit per clock over 15 clocks. A single-cycle done pulse marks the moment the results and the overflow flag are valid, and they stay unchanged until the next accepted start. A faulting request skips the loop and signals done on the cycle after it is accepted.

Top module: `dword_divider`

## Requirements
- R1: After reset, busy, done, ovfOut, accOut and idxOut are all 0.
- R2: The dividend is the 31-bit value {accIn[15:0], idxIn[15:1]}. idxIn[0] has no effect on any result.
- R3: When divisorIn <= accIn (both treated as unsigned, positive operands), the request faults. done rises on the cycle after acceptance, ovfOut is 1, accOut equals the accepted accIn and idxOut equals the accepted idxIn.
- R4: When divisorIn > accIn, done rises 16 cycles after the accepting edge. idxOut is {1'b0, quotient[14:0]} and accOut is the remainder.
- R5: On a request without a fault, ovfOut at done equals the ovfIn latched at acceptance.
- R6: done is high for exactly one cycle per accepted request. busy is high from the cycle after acceptance through the done cycle.
- R7: A start asserted while busy is high, including during the done cycle, is ignored. It does not alter the result in progress and does not produce a done pulse.
- R8: accOut, idxOut and ovfOut hold their done-cycle values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when not busy |
| accIn | input | 16 | A register: dividend sign and high-order 15 bits |
| idxIn | input | 16 | X register: dividend low 15 bits in bits 15..1 |
| divisorIn | input | 16 | Positive divisor word |
| ovfIn | input | 1 | Overflow flag before the operation |
| busy | output | 1 | Request in progress, new starts ignored |
| done | output | 1 | One-cycle completion pulse |
| accOut | output | 16 | New A: remainder, or the old A on a fault |
| idxOut | output | 16 | New X: quotient, or the old X on a fault |
| ovfOut | output | 1 | New overflow flag |

## Verification
The collision of interest is a fresh start request arriving on the same cycle as a completion. This is worst on a faulting request, where the done cycle directly follows acceptance. The bench provokes it by raising start again, with different operands, on the cycle after each accepted request. That cycle falls mid-loop on a normal division and lands exactly on the done pulse on a fault. It judges the outcome through its scoreboard: every done must match the one queued expectation from the original operands, at the expected latency. Any extra done, or a second done on consecutive cycles, counts as a mismatch.

// File: rtl/dwdiv_pkg.sv
package dwdiv_pkg;
  // Strobes issued by the sequencer to the arithmetic datapath.
  typedef struct packed {
    logic load;   // latch operands, decide fault
    logic step;   // one restoring shift-subtract iteration
  } dwStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } dwState_t;
endpackage

// File: rtl/dwdiv_ctrl.sv
module dwdiv_ctrl
  import dwdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       faultNow,
  output dwStrobe_t  strobe,
  output logic       busy,
  output logic       done
);
  localparam int STEPS = WIDTH - 1;
  localparam int CNT_W = $clog2(STEPS + 1);

  dwState_t         state;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state   <= faultNow ? ST_DONE : ST_RUN;
          stepCnt <= '0;
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CNT_W'(STEPS - 1)) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: load and iterate never coincide
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.step}));
  // R7: an idle start is always taken and makes the block busy
  a_r7_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy);
endmodule

// File: rtl/dwdiv_datapath.sv
module dwdiv_datapath
  import dwdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dwStrobe_t        strobe,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] idxIn,
  input  logic [WIDTH-1:0] divisorIn,
  input  logic             ovfIn,
  output logic             faultNow,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] idxOut,
  output logic             ovfOut
);
  localparam int LOW_W = WIDTH - 1;

  logic [WIDTH-1:0] remReg;
  logic [LOW_W-1:0] quoReg;
  logic [WIDTH-1:0] divReg;
  logic [WIDTH-1:0] xHold;
  logic             faultReg;
  logic             ovfSave;

  logic [WIDTH:0]   trial;
  logic [WIDTH:0]   diff;
  logic             take;

  assign faultNow = (divisorIn <= accIn);

  always_comb begin
    trial = {remReg, quoReg[LOW_W-1]};
    diff  = trial - {1'b0, divReg};
    take  = !diff[WIDTH];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg   <= '0;
      quoReg   <= '0;
      divReg   <= '0;
      xHold    <= '0;
      faultReg <= 1'b0;
      ovfSave  <= 1'b0;
    end else if (strobe.load) begin
      remReg   <= accIn;
      quoReg   <= idxIn[WIDTH-1:1];
      divReg   <= divisorIn;
      xHold    <= idxIn;
      faultReg <= faultNow;
      ovfSave  <= ovfIn;
    end else if (strobe.step) begin
      remReg <= take ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
      quoReg <= {quoReg[LOW_W-2:0], take};
    end
  end

  assign accOut = remReg;
  assign idxOut = faultReg ? xHold : {1'b0, quoReg};
  assign ovfOut = faultReg | ovfSave;

  // R3: a fault sets the flag and leaves both registers as they were
  a_r3_fault_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && faultNow) |=>
      (ovfOut && accOut == $past(accIn) && idxOut == $past(idxIn)));
  // R4: partial remainder stays below the divisor
  a_r4_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> (remReg < divReg));
  // R5: a non-faulting request carries the incoming flag
  a_r5_ovf_restore: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !faultNow) |=> (ovfOut == $past(ovfIn)));
endmodule

// File: rtl/dword_divider.sv
module dword_divider
  import dwdiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] accIn,
  input  logic [WIDTH-1:0] idxIn,
  input  logic [WIDTH-1:0] divisorIn,
  input  logic             ovfIn,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] accOut,
  output logic [WIDTH-1:0] idxOut,
  output logic             ovfOut
);
  dwStrobe_t strobe;
  logic      faultNow;

  dwdiv_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .faultNow(faultNow),
    .strobe(strobe), .busy(busy), .done(done)
  );

  dwdiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .accIn(accIn), .idxIn(idxIn), .divisorIn(divisorIn), .ovfIn(ovfIn),
    .faultNow(faultNow), .accOut(accOut), .idxOut(idxOut), .ovfOut(ovfOut)
  );
endmodule

// File: tb/dword_divider_tb.sv
module dword_divider_tb;
  logic clk = 0;
  logic rstN = 0;
  logic start = 0;
  logic [15:0] accIn = 0, idxIn = 0, divisorIn = 0;
  logic ovfIn = 0;
  logic busy, done, ovfOut;
  logic [15:0] accOut, idxOut;

  always #10 clk = ~clk;  // 50 MHz

  dword_divider u_dut (
    .clk(clk), .rstN(rstN), .start(start), .accIn(accIn), .idxIn(idxIn),
    .divisorIn(divisorIn), .ovfIn(ovfIn), .busy(busy), .done(done),
    .accOut(accOut), .idxOut(idxOut), .ovfOut(ovfOut)
  );

  typedef struct {
    logic [15:0] a;
    logic [15:0] x;
    logic        o;
    int          lat;
    int          t0;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;
  int nChk = 0, nBad = 0, cyc = 0;
  bit prevDone = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops one expectation per done pulse
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) chk("R6 done twice in a row", 1, 0);
      if (done) begin
        if (expQ.size() == 0) chk("R7 unexpected done", 1, 0);
        else begin
          expItem_t e;
          e = expQ.pop_front();
          chk({e.tag, " accOut"}, accOut, e.a);
          chk({e.tag, " idxOut"}, idxOut, e.x);
          chk({e.tag, " ovfOut"}, ovfOut, e.o);
          chk({e.tag, " latency"}, cyc - e.t0, e.lat);
          lastExp = e;
        end
      end
      prevDone = done;
    end
  end

  // Driver: computes expectation, starts, optionally pokes start again
  task automatic runOp(input logic [15:0] a, input logic [15:0] x,
                       input logic [15:0] v, input logic o, input string tag);
    expItem_t e;
    logic [30:0] dd;
    logic [30:0] q, r;
    while (busy) @(negedge clk);
    dd = {a, x[15:1]};
    if (v <= a) begin
      e.a = a; e.x = x; e.o = 1'b1; e.lat = 1;
      e.tag = {"R3 fault ", tag};
    end else begin
      q = dd / {15'd0, v};
      r = dd % {15'd0, v};
      e.a = r[15:0]; e.x = {1'b0, q[14:0]}; e.o = o; e.lat = 16;
      e.tag = {"R4/R5 div ", tag};
    end
    e.t0 = cyc;
    expQ.push_back(e);
    accIn = a; idxIn = x; divisorIn = v; ovfIn = o; start = 1;
    @(negedge clk);
    chk("R6 busy after accept", busy, 1);
    // R7: second request while busy (on the done cycle for a fault)
    accIn = 16'h0001; idxIn = 16'h0002; divisorIn = 16'h0003; ovfIn = ~o;
    @(negedge clk);
    start = 0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    // R8: outputs hold after done
    chk("R8 hold accOut", accOut, lastExp.a);
    chk("R8 hold idxOut", idxOut, lastExp.x);
    chk("R8 hold ovfOut", ovfOut, lastExp.o);
    chk("R6 idle after done", busy, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin : stim
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 ovfOut", ovfOut, 0);
    chk("R1 accOut", accOut, 0);
    chk("R1 idxOut", idxOut, 0);
    rstN = 1;
    @(negedge clk);
    runOp(16'h0000, 16'h0002, 16'h0001, 1'b0, "unit");
    runOp(16'h1234, 16'hABCD, 16'h7FFF, 1'b0, "mid");
    runOp(16'h7FFE, 16'hFFFF, 16'h7FFF, 1'b0, "maxq");
    runOp(16'h0100, 16'h5556, 16'h0101, 1'b1, "ovf kept");
    // R2: bit 0 of X differs, results must match
    runOp(16'h0ABC, 16'h1234, 16'h0F00, 1'b0, "R2 x0=0");
    runOp(16'h0ABC, 16'h1235, 16'h0F00, 1'b0, "R2 x0=1");
    runOp(16'h0005, 16'h4321, 16'h0005, 1'b0, "equal");
    runOp(16'h0400, 16'h8001, 16'h0010, 1'b0, "less");
    runOp(16'h0000, 16'h0000, 16'h0000, 1'b1, "zero");
    seed = 32'h1ACE_5EED;
    for (int i = 0; i < 40; i++) begin
      logic [15:0] a, x, v;
      seed = seed * 32'd1664525 + 32'd1013904223;
      a = {1'b0, seed[30:16]} >> seed[3:0];
      x = seed[15:0];
      seed = seed * 32'd1664525 + 32'd1013904223;
      v = {1'b0, seed[30:16]};
      runOp(a, x, v, seed[5], "sweep");
    end
    summary();
  end
endmodule